// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register Block

This block holds the routing configuration for up to 32 interrupt pins behind a two-register bus window. Software first writes an index into a 32-bit selector register, then reads or writes the selected internal register through a 32-bit data window. The internal space holds an identification register, a read-only version word, an arbitration word that mirrors the identification value, and a table with one 64-bit routing entry per pin. Each entry is reached as two 32-bit halves.

All entries are presented in parallel to a separate dispatch block, together with a per-pin strobe that marks a freshly written entry. A pulse flags any write that altered routing-relevant bits. The dispatch block owns the two status bits of each entry. It sets and clears the remote-acknowledge bit through per-pin inputs and reports delivery status on a per-pin input. Bus writes cannot alter either bit, with one exception: a write that leaves an entry in edge mode clears its remote-acknowledge bit.

Entry bit layout: vector [7:0], delivery mode [10:8], destination mode 11, delivery status 12, polarity 13, remote-acknowledge 14, trigger mode 15 (1 = level), mask 16, destination [63:56].

Top module: `irq_redir_regs`

## Requirements
- R1: Only accesses with `acc_size` = 4 at offset 0x00 (selector) or 0x10 (window) take effect. Any other write changes nothing. Any other read returns zero.
- R2: Each read access is answered one cycle later, with `rd_valid` high for one cycle and the data on `rd_data`.
- R3: The selector reads back all 32 bits written to it. Only its low 8 bits are decoded as the internal index.
- R4: Index 0x00 is the identification register, which keeps only bits 27:24 of a write. Index 0x02 returns the identification value. Index 0x01 returns (entries-1) shifted left by 16, ORed with 0x11, which is 0x001F0011 for 32 entries. Writes to indices 0x01 and 0x02 are ignored.
- R5: Index 0x10+2p selects bits 31:0 of entry p and index 0x11+2p selects bits 63:32. A write replaces only the selected half.
- R6: Bits 12 (delivery status) and 14 (remote-acknowledge) are not changed by bus writes. Bit 14 is set by a pulse on `irr_set[p]` and cleared by a pulse on `irr_clr[p]`. Bit 12 follows `dlv_status[p]` one cycle late.
- R7: If an entry's bit 15 is 0 after a write to it, its bit 14 is 0 after that write, whatever its previous value.
- R8: After reset every entry is 0x0001000000010000, so every pin is masked. The identification register and the selector are 0.
- R9: One cycle after a window write to either half of entry p, bit p of `entry_wr_strobe` is high for exactly one cycle and `entry_flat` already holds the new value.
- R10: `cfg_change` pulses together with the strobe when that write changed any entry bit other than bit 16 (mask) or bit 13 (polarity).
- R11: Indices that are not implemented (0x03 to 0x0F, and 0x50 and above) read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Bus access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset of the access |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response pulse |
| irr_set | input | 32 | Per-pin set of remote-acknowledge bit |
| irr_clr | input | 32 | Per-pin clear of remote-acknowledge bit |
| dlv_status | input | 32 | Per-pin delivery status from the dispatch block |
| entry_flat | output | 2048 | All entries; entry p at bits 64p+63:64p |
| entry_wr_strobe | output | 32 | Per-pin pulse after a write to that entry |
| cfg_change | output | 1 | Pulse after a write that changed routing bits |

## Verification
Every result in this block is due exactly one cycle after the access that causes it. Read data and `rd_valid` appear one cycle after the read. Entry contents, the per-pin strobe and the change pulse appear one cycle after the window write. A status-input pulse is visible in the entry one cycle later. The bench drives on falling edges, so each bus access occupies one rising edge, and it samples on the next falling edge, exactly when those registered results first show. Expected read words go into a queue when the read is issued. A monitor pops one entry on every falling edge with `rd_valid`, so a late, early or missing response shows up as a mismatch or as a leftover queue entry.

// File: rtl/irq_redir_pkg.sv
// Shared constants and types for the indirect interrupt redirection block.
// Assumes 64-bit entries split into two 32-bit halves and an 8-bit index space.
package irq_redir_pkg;

    localparam int ENTRY_W  = 64;
    localparam int HALF_W   = 32;

    // entry field positions that the dispatch block decodes
    localparam int BIT_DLV  = 12;
    localparam int BIT_POL  = 13;
    localparam int BIT_RIRR = 14;
    localparam int BIT_TRIG = 15;
    localparam int BIT_MASK = 16;

    localparam logic [ENTRY_W-1:0] ENTRY_RST  = 64'h0001_0000_0001_0000;
    localparam logic [HALF_W-1:0]  LO_RO_MASK = (32'h1 << BIT_DLV) | (32'h1 << BIT_RIRR);
    localparam logic [ENTRY_W-1:0] CHG_IGNORE = (64'h1 << BIT_MASK) | (64'h1 << BIT_POL);

    // internal index map
    localparam logic [7:0] IDX_ID       = 8'h00;
    localparam logic [7:0] IDX_VER      = 8'h01;
    localparam logic [7:0] IDX_ARB      = 8'h02;
    localparam logic [7:0] IDX_TBL_BASE = 8'h10;

    localparam logic [31:0] ID_FIELD_MASK  = 32'h0F00_0000;
    localparam int          VER_MAXRED_LSB = 16;
    localparam logic [7:0]  VER_CODE       = 8'h11;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_ID,
        KIND_VER,
        KIND_ARB,
        KIND_TBL
    } reg_kind_e;

    // version word for a table of n entries
    function automatic logic [31:0] version_word(input int n);
        return (32'(n - 1) << VER_MAXRED_LSB) | {24'h0, VER_CODE};
    endfunction

endpackage

// File: rtl/irq_sel_decode.sv
// Bus-side front end: qualifies accesses, holds the selector register and
// decodes the selected internal index into a register kind, entry number and half.
// Assumes one-cycle access strobes and NUM_ENTRIES between 2 and 56.
module irq_sel_decode
    import irq_redir_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NUM_ENTRIES = 32,
    localparam int PIN_W      = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    output logic [31:0]       sel_q,
    output logic              sel_rd,
    output logic              win_rd,
    output logic              win_wr,
    output reg_kind_e         kind,
    output logic [PIN_W-1:0]  ent_idx,
    output logic              ent_hi
);

    localparam logic [ADDR_W-1:0] OFF_SEL = '0;
    localparam logic [ADDR_W-1:0] OFF_WIN = ADDR_W'(16);
    localparam logic [8:0]        TBL_END = 9'(16 + 2 * NUM_ENTRIES);

    logic             acc_ok;
    logic             sel_wr;
    logic [7:0]       idx;
    logic [PIN_W:0]   tbl_off;

    // qualify size and offset of the current access
    always_comb begin
        acc_ok = (acc_size == 3'd4) && ((acc_addr == OFF_SEL) || (acc_addr == OFF_WIN));
        sel_wr = acc_valid &&  acc_write && acc_ok && (acc_addr == OFF_SEL);
        sel_rd = acc_valid && !acc_write && acc_ok && (acc_addr == OFF_SEL);
        win_wr = acc_valid &&  acc_write && acc_ok && (acc_addr == OFF_WIN);
        win_rd = acc_valid && !acc_write && acc_ok && (acc_addr == OFF_WIN);
    end

    // selector register, full 32 bits kept for readback
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else if (sel_wr) sel_q <= acc_wdata;
    end

    // decode the low selector byte into a register kind and table position
    always_comb begin
        idx     = sel_q[7:0];
        tbl_off = (PIN_W + 1)'(idx - IDX_TBL_BASE);
        ent_idx = tbl_off[PIN_W:1];
        ent_hi  = tbl_off[0];
        if (idx == IDX_ID)       kind = KIND_ID;
        else if (idx == IDX_VER) kind = KIND_VER;
        else if (idx == IDX_ARB) kind = KIND_ARB;
        else if (({1'b0, idx} >= {1'b0, IDX_TBL_BASE}) && ({1'b0, idx} < TBL_END))
                                 kind = KIND_TBL;
        else                     kind = KIND_NONE;
    end

    AST_SEL_ONLY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != $past(sel_q)) |-> $past(acc_valid && acc_write && acc_size == 3'd4 && acc_addr == OFF_SEL))
        else $error("selector changed without a qualified write"); // R3

endmodule

// File: rtl/irq_redir_entry.sv
// One 64-bit routing entry: half-word writes, protected status bits,
// edge-mode acknowledge clear, status inputs from the dispatch block,
// and registered write and change pulses.
// Assumes wr_en is a single-cycle strobe.
module irq_redir_entry
    import irq_redir_pkg::*;
#(
    parameter logic [ENTRY_W-1:0] RST_VAL = ENTRY_RST
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_hi,
    input  logic [HALF_W-1:0]  wr_data,
    input  logic               irr_set,
    input  logic               irr_clr,
    input  logic               dlv_in,
    output logic [ENTRY_W-1:0] entry_q,
    output logic               wr_pulse,
    output logic               chg_pulse
);

    logic [ENTRY_W-1:0] wr_val;
    logic [ENTRY_W-1:0] base;
    logic [ENTRY_W-1:0] nxt;
    logic               chg_now;
    logic               edge_clr;

    // value the entry takes from a bus write, status bits protected
    always_comb begin
        wr_val = entry_q;
        if (wr_hi) wr_val[ENTRY_W-1:HALF_W] = wr_data;
        else       wr_val[HALF_W-1:0] = (wr_data & ~LO_RO_MASK) | (entry_q[HALF_W-1:0] & LO_RO_MASK);
        if (!wr_val[BIT_TRIG]) wr_val[BIT_RIRR] = 1'b0;
        chg_now  = |((entry_q ^ wr_val) & ~CHG_IGNORE);
        edge_clr = wr_en && !wr_val[BIT_TRIG];
    end

    // merge the write with the dispatch-side status updates
    always_comb begin
        base          = wr_en ? wr_val : entry_q;
        nxt           = base;
        nxt[BIT_DLV]  = dlv_in;
        if (!edge_clr) nxt[BIT_RIRR] = (base[BIT_RIRR] | irr_set) & ~irr_clr;
    end

    // entry storage and one-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q   <= RST_VAL;
            wr_pulse  <= 1'b0;
            chg_pulse <= 1'b0;
        end else begin
            entry_q   <= nxt;
            wr_pulse  <= wr_en;
            chg_pulse <= wr_en && chg_now;
        end
    end

    AST_DLV_MIRRORS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (entry_q[BIT_DLV] == $past(dlv_in)))
        else $error("delivery status does not follow input"); // R6
    AST_EDGE_CLEARS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && !entry_q[BIT_TRIG]) |-> !entry_q[BIT_RIRR])
        else $error("remote ack survived an edge-mode write"); // R7
    AST_HI_KEPT_ON_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi) |=> (entry_q[ENTRY_W-1:HALF_W] == $past(entry_q[ENTRY_W-1:HALF_W])))
        else $error("high half changed by low-half write"); // R5
    AST_LO_KEPT_ON_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> ((entry_q[HALF_W-1:0] & ~LO_RO_MASK) == $past(entry_q[HALF_W-1:0] & ~LO_RO_MASK)))
        else $error("low half changed by high-half write"); // R5

endmodule

// File: rtl/irq_read_mux.sv
// Registered read path: selects selector, ID, version, arbitration or a
// table half, and returns zero for ignored accesses and unimplemented indices.
// Assumes one read response per read access, one cycle later.
module irq_read_mux
    import irq_redir_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    localparam int PIN_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_req,
    input  logic                           sel_rd,
    input  logic                           win_rd,
    input  reg_kind_e                      kind,
    input  logic [PIN_W-1:0]               ent_idx,
    input  logic                           ent_hi,
    input  logic [31:0]                    sel_q,
    input  logic [31:0]                    id_q,
    input  logic [NUM_ENTRIES*ENTRY_W-1:0] ent_flat,
    output logic [31:0]                    rd_data,
    output logic                           rd_valid
);

    localparam logic [31:0] VER_WORD = version_word(NUM_ENTRIES);

    logic [31:0] win_val;
    logic [31:0] rd_nxt;

    // window contents for the decoded index
    always_comb begin
        case (kind)
            KIND_ID:  win_val = id_q;
            KIND_VER: win_val = VER_WORD;
            KIND_ARB: win_val = id_q;
            KIND_TBL: win_val = ent_flat[{ent_idx, ent_hi, 5'b0} +: 32];
            default:  win_val = '0;
        endcase
        if (sel_rd)      rd_nxt = sel_q;
        else if (win_rd) rd_nxt = win_val;
        else             rd_nxt = '0;
    end

    // response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_data  <= rd_req ? rd_nxt : '0;
            rd_valid <= rd_req;
        end
    end

    AST_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0))
        else $error("read data present without response"); // R2

endmodule

// File: rtl/irq_redir_regs.sv
// Top of the indirect interrupt redirection register block. Ties the bus
// decoder, the identification register, one entry slice per pin and the
// read path together, and presents the entries to the dispatch block.
// Assumes a single bus master issuing one-cycle access strobes.
module irq_redir_regs
    import irq_redir_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NUM_ENTRIES = 32,
    localparam int PIN_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           acc_valid,
    input  logic                           acc_write,
    input  logic [ADDR_W-1:0]              acc_addr,
    input  logic [2:0]                     acc_size,
    input  logic [31:0]                    acc_wdata,
    output logic [31:0]                    rd_data,
    output logic                           rd_valid,
    input  logic [NUM_ENTRIES-1:0]         irr_set,
    input  logic [NUM_ENTRIES-1:0]         irr_clr,
    input  logic [NUM_ENTRIES-1:0]         dlv_status,
    output logic [NUM_ENTRIES*ENTRY_W-1:0] entry_flat,
    output logic [NUM_ENTRIES-1:0]         entry_wr_strobe,
    output logic                           cfg_change
);

    logic [31:0]            sel_q;
    logic                   sel_rd;
    logic                   win_rd;
    logic                   win_wr;
    reg_kind_e              kind;
    logic [PIN_W-1:0]       ent_idx;
    logic                   ent_hi;
    logic [31:0]            id_q;
    logic [NUM_ENTRIES-1:0] chg_vec;
    logic                   acc_bad;

    irq_sel_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .acc_wdata (acc_wdata),
        .sel_q     (sel_q),
        .sel_rd    (sel_rd),
        .win_rd    (win_rd),
        .win_wr    (win_wr),
        .kind      (kind),
        .ent_idx   (ent_idx),
        .ent_hi    (ent_hi)
    );

    // identification register, only the ID field is writable
    always_ff @(posedge clk) begin
        if (!rst_n) id_q <= '0;
        else if (win_wr && kind == KIND_ID) id_q <= acc_wdata & ID_FIELD_MASK;
    end

    for (genvar p = 0; p < NUM_ENTRIES; p++) begin : g_entry
        logic ent_wr;
        // write enable for this pin's entry
        always_comb ent_wr = win_wr && (kind == KIND_TBL) && (ent_idx == PIN_W'(p));

        irq_redir_entry #(
            .RST_VAL (ENTRY_RST)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (ent_wr),
            .wr_hi     (ent_hi),
            .wr_data   (acc_wdata),
            .irr_set   (irr_set[p]),
            .irr_clr   (irr_clr[p]),
            .dlv_in    (dlv_status[p]),
            .entry_q   (entry_flat[p*ENTRY_W +: ENTRY_W]),
            .wr_pulse  (entry_wr_strobe[p]),
            .chg_pulse (chg_vec[p])
        );
    end

    // configuration change summary for the dispatch block
    always_comb cfg_change = |chg_vec;

    irq_read_mux #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (acc_valid && !acc_write),
        .sel_rd   (sel_rd),
        .win_rd   (win_rd),
        .kind     (kind),
        .ent_idx  (ent_idx),
        .ent_hi   (ent_hi),
        .sel_q    (sel_q),
        .id_q     (id_q),
        .ent_flat (entry_flat),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // access that the block must ignore
    always_comb acc_bad = (acc_size != 3'd4) || ((acc_addr != '0) && (acc_addr != ADDR_W'(16)));

    AST_IGNORED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_valid && !acc_write && acc_bad) |-> (rd_data == '0))
        else $error("ignored read returned data"); // R1
    AST_IGNORED_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_valid && acc_write && acc_bad) |-> (entry_wr_strobe == '0))
        else $error("ignored write touched an entry"); // R1
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(entry_wr_strobe))
        else $error("more than one entry strobe"); // R9
    AST_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_change |-> (entry_wr_strobe != '0))
        else $error("change pulse without entry write"); // R10

endmodule

// File: tb/irq_redir_regs_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue the expected word, a monitor pops and
// compares on each read response; strobes and entry contents are checked
// directly at the falling edge after each write.
module irq_redir_regs_tb;

    localparam int N = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_valid = 1'b0;
    logic            acc_write = 1'b0;
    logic [7:0]      acc_addr = '0;
    logic [2:0]      acc_size = '0;
    logic [31:0]     acc_wdata = '0;
    logic [31:0]     rd_data;
    logic            rd_valid;
    logic [N-1:0]    irr_set = '0;
    logic [N-1:0]    irr_clr = '0;
    logic [N-1:0]    dlv_status = '0;
    logic [N*64-1:0] entry_flat;
    logic [N-1:0]    entry_wr_strobe;
    logic            cfg_change;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          timed_out = 1'b0;

    always #4 clk = ~clk;

    irq_redir_regs u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .acc_valid       (acc_valid),
        .acc_write       (acc_write),
        .acc_addr        (acc_addr),
        .acc_size        (acc_size),
        .acc_wdata       (acc_wdata),
        .rd_data         (rd_data),
        .rd_valid        (rd_valid),
        .irr_set         (irr_set),
        .irr_clr         (irr_clr),
        .dlv_status      (dlv_status),
        .entry_flat      (entry_flat),
        .entry_wr_strobe (entry_wr_strobe),
        .cfg_change      (cfg_change)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare each read response with the queued expectation
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected response actual=%h expected=none", rd_data);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, rd_data, e);
                end
            end
        end
    end

    task automatic bus_op(input logic wr, input logic [7:0] addr, input logic [2:0] size, input logic [31:0] data);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = addr; acc_size = size; acc_wdata = data;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd_exp(input logic [7:0] addr, input logic [2:0] size, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_op(1'b0, addr, size, 32'h0);
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [31:0] data);
        bus_op(1'b1, 8'h00, 3'd4, {24'h0, idx});
        bus_op(1'b1, 8'h10, 3'd4, data);
    endtask

    task automatic reg_rd(input logic [7:0] idx, input logic [31:0] exp, input string tag);
        bus_op(1'b1, 8'h00, 3'd4, {24'h0, idx});
        rd_exp(8'h10, 3'd4, exp, tag);
    endtask

    task automatic pulse_set(input int p);
        @(negedge clk); irr_set[p] = 1'b1;
        @(negedge clk); irr_set[p] = 1'b0;
    endtask

    task automatic pulse_clr(input int p);
        @(negedge clk); irr_clr[p] = 1'b1;
        @(negedge clk); irr_clr[p] = 1'b0;
    endtask

    function automatic logic [63:0] ent(input int p);
        return entry_flat[p*64 +: 64];
    endfunction

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk("R8 rd_valid", 64'(rd_valid), 64'h0);
        chk("R8 rd_data", 64'(rd_data), 64'h0);
        chk("R8 strobe", 64'(entry_wr_strobe), 64'h0);
        chk("R8 cfg", 64'(cfg_change), 64'h0);
        chk("R8 entry0", ent(0), 64'h0001000000010000);
        chk("R8 entry31", ent(31), 64'h0001000000010000);
        rd_exp(8'h00, 3'd4, 32'h0, "R8 selector");
        reg_rd(8'h10, 32'h00010000, "R8 entry0 low");
        reg_rd(8'h11, 32'h00010000, "R8 entry0 high");
        reg_rd(8'h00, 32'h0, "R8 id");

        // R3 selector readback and low-byte decode
        bus_op(1'b1, 8'h00, 3'd4, 32'h12345601);
        rd_exp(8'h00, 3'd4, 32'h12345601, "R3 selector readback");
        rd_exp(8'h10, 3'd4, 32'h001F0011, "R3 R4 version via upper-bit selector");

        // R4 id, arbitration, version
        reg_wr(8'h00, 32'hFFFFFFFF);
        reg_rd(8'h00, 32'h0F000000, "R4 id masked");
        reg_rd(8'h02, 32'h0F000000, "R4 arbitration mirrors id");
        reg_wr(8'h02, 32'h0);
        reg_rd(8'h02, 32'h0F000000, "R4 arbitration write ignored");
        reg_wr(8'h01, 32'h0);
        reg_rd(8'h01, 32'h001F0011, "R4 version write ignored");

        // R1 qualification
        bus_op(1'b1, 8'h00, 3'd4, 32'h16);
        bus_op(1'b1, 8'h00, 3'd2, 32'h05);
        rd_exp(8'h00, 3'd4, 32'h16, "R1 short selector write ignored");
        rd_exp(8'h04, 3'd4, 32'h0, "R1 other offset reads zero");
        rd_exp(8'h00, 3'd2, 32'h0, "R1 short read zero");
        bus_op(1'b1, 8'h10, 3'd1, 32'hFFFFFFFF);
        chk("R1 short window write no strobe", 64'(entry_wr_strobe), 64'h0);
        bus_op(1'b1, 8'h08, 3'd4, 32'hFFFFFFFF);
        chk("R1 odd offset write no strobe", 64'(entry_wr_strobe), 64'h0);
        rd_exp(8'h10, 3'd4, 32'h00010000, "R1 entry3 untouched");

        // R5 R6 R9 R10 first write to entry 3 low half
        bus_op(1'b1, 8'h10, 3'd4, 32'hFFFFFFFF);
        chk("R9 strobe entry3", 64'(entry_wr_strobe), 64'h8);
        chk("R10 change on write", 64'(cfg_change), 64'h1);
        rd_exp(8'h10, 3'd4, 32'hFFFFAFFF, "R6 status bits protected");
        chk("R9 strobe one cycle", 64'(entry_wr_strobe), 64'h0);
        reg_rd(8'h17, 32'h00010000, "R5 high half untouched");
        reg_wr(8'h17, 32'h00010000);
        chk("R9 strobe high write", 64'(entry_wr_strobe), 64'h8);
        chk("R10 no change same value", 64'(cfg_change), 64'h0);
        reg_wr(8'h17, 32'hAB010000);
        chk("R10 change destination", 64'(cfg_change), 64'h1);
        chk("R5 entry3 halves", ent(3), 64'hAB010000_FFFFAFFF);
        reg_wr(8'h16, 32'hFFFE8FFF);
        chk("R10 mask polarity only", 64'(cfg_change), 64'h0);
        chk("R9 strobe mask write", 64'(entry_wr_strobe), 64'h8);
        chk("R5 entry3 low", ent(3), 64'hAB010000_FFFE8FFF);

        // R6 status bits
        pulse_set(3);
        reg_rd(8'h16, 32'hFFFECFFF, "R6 ack set");
        reg_wr(8'h16, 32'hFFFE8FFF);
        chk("R10 ack kept no change", 64'(cfg_change), 64'h0);
        reg_rd(8'h16, 32'hFFFECFFF, "R6 ack survives level write");
        @(negedge clk); dlv_status[3] = 1'b1;
        reg_rd(8'h16, 32'hFFFEDFFF, "R6 delivery status");
        pulse_clr(3);
        reg_rd(8'h16, 32'hFFFE9FFF, "R6 ack clear");
        pulse_set(3);

        // R7 edge mode clears ack
        reg_wr(8'h16, 32'hFFFE0FFF);
        chk("R10 trigger change", 64'(cfg_change), 64'h1);
        reg_rd(8'h16, 32'hFFFE1FFF, "R7 edge write clears ack");
        pulse_set(3);
        reg_rd(8'h16, 32'hFFFE5FFF, "R6 ack set in edge mode");
        reg_wr(8'h16, 32'hFFFE0FFF);
        chk("R10 ack clear counts", 64'(cfg_change), 64'h1);
        reg_rd(8'h16, 32'hFFFE1FFF, "R7 repeat edge write clears ack");
        @(negedge clk); dlv_status[3] = 1'b0;

        // R11 unimplemented indices
        reg_wr(8'h05, 32'hFFFFFFFF);
        chk("R11 no strobe", 64'(entry_wr_strobe), 64'h0);
        chk("R11 no change", 64'(cfg_change), 64'h0);
        reg_rd(8'h05, 32'h0, "R11 gap index");
        reg_rd(8'h0F, 32'h0, "R11 below table");
        reg_wr(8'h50, 32'hFFFFFFFF);
        chk("R11 past table no strobe", 64'(entry_wr_strobe), 64'h0);
        reg_rd(8'h50, 32'h0, "R11 past table");
        bus_op(1'b1, 8'h00, 3'd4, 32'hFFFFFF16);
        rd_exp(8'h10, 3'd4, 32'hFFFE0FFF, "R3 upper selector bits ignored");

        // R5 R9 last entry
        reg_wr(8'h4F, 32'hC3000000);
        chk("R9 strobe entry31", 64'(entry_wr_strobe), 64'h80000000);
        chk("R5 entry31", ent(31), 64'hC3000000_00010000);
        reg_rd(8'h4E, 32'h00010000, "R5 entry31 low");

        repeat (3) @(negedge clk);
        chk("R2 all responses seen", 64'(exp_q.size()), 64'h0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=hung expected=complete");
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule